// File: doc/BRIEF.md
# Snapshot-buffered calendar register window

This block puts a real-time calendar behind eight byte-wide registers at the top of an asynchronous SRAM-style address space. Behind the registers sits a live binary calendar chain (seconds through year) that advances on a one-second strobe. A host never reads that chain directly. It reads a set of visible BCD registers that follow the chain once per second. The host can freeze those registers for a coherent read, or hold them while it stages a new time. Clearing the write-hold bit loads the staged time into the live chain.

The bus follows chip-enable, output-enable and write-enable strobes and is sampled on the system clock. Read data and its drive enable are registered. Addresses below the window go to an external RAM port. Only that port's chip-enable is gated; address, data and strobes pass through unchanged. A synchronous power-fail input blocks all register and RAM access and pulls an active-low fail flag. The calendar keeps counting while power-fail is asserted.

Top module: `rtc_regwin`

## Requirements
- R1: Registers sit where the address bits above bit 2 are all ones, and address bits [2:0] pick one: 7 year, 6 month, 5 date, 4 day-of-week, 3 hour, 2 minutes, 1 seconds, 0 control. Time values are two-digit BCD. After reset they read year 00, month 01, date 01, day 01, and 00 for hour, minutes, seconds and control.
- R2: Control bit 7 is the write-hold bit and bit 6 is the read-hold bit. Control bits 5..0 always read 0.
- R3: While neither hold bit is set, the visible time registers take the live count on the clock edge after each one-second strobe.
- R4: While read-hold is 1, the visible registers do not change, but the live chain keeps counting. After read-hold returns to 0, the next strobe shows the current count.
- R5: While write-hold is 1, host writes land in the visible registers and stay there. Writing control with bit 7 = 0 while write-hold is 1 loads all seven time registers into the live chain. Counting then continues from the loaded time.
- R6: The live chain rolls seconds and minutes after 59, hours after 23, day-of-week from 7 to 1, date after the month's length, month after 12, and year from 99 to 00. February has 29 days when the year is a multiple of 4 (00 included).
- R7: Seconds bit 7 is a stop bit. While it is 1, the live chain does not advance. It reads back as written.
- R8: Day-of-week bit 6 is a frequency-test flag that is stored and read back.
- R9: Unused bits are dropped on write and read as 0: month [7:5], date [7:6], day-of-week [7] and [5:3], hour [7:6], minutes [7], control [5:0].
- R10: A register write happens on a clock edge where chip-enable and write-enable are both low. A read happens with chip-enable low and write-enable high. The output-enable flag rises one cycle later, with the data, only if output-enable was also low.
- R11: While power-fail is high, register writes are dropped and no data is driven. The fail flag goes low on the next clock edge and stays low until the edge after power-fail clears.
- R12: The RAM chip-enable is low only when chip-enable is low, power-fail is low and the address is outside the window. Address, write data, write-enable and output-enable reach the RAM port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle strobe per second |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous |
| cs_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| dq_out | output | 8 | Registered read data |
| dq_oe | output | 1 | Read data drive enable |
| pf_n | output | 1 | Power-fail flag, active low |
| ram_ce_n | output | 1 | Gated chip enable for external RAM |
| ram_oe_n | output | 1 | Output enable to RAM |
| ram_we_n | output | 1 | Write enable to RAM |
| ram_addr | output | ADDR_W | Address to RAM |
| ram_wdata | output | 8 | Write data to RAM |

## Verification
Hidden state shows up only through reads, so errors appear late. A wrong live chain stays hidden until the next strobe copies it into the visible registers, or until a freeze and release exposes it, which can be many cycles after the cause. A hold bit that is decoded wrongly shows up as a visible register that moves under a freeze, or that fails to move one edge after a strobe. A lost transfer shows up only at the first strobe after write-hold is released. The bench steps a behavioural model on every edge and compares drive enable, data, fail flag and RAM chip-enable. Each error is therefore caught at the first read that depends on it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 8;
  localparam int SEL_W     = $clog2(NUM_REGS);

  typedef enum logic [SEL_W-1:0] {
    REG_CTRL = 3'd0,
    REG_SEC  = 3'd1,
    REG_MIN  = 3'd2,
    REG_HOUR = 3'd3,
    REG_DOW  = 3'd4,
    REG_DATE = 3'd5,
    REG_MON  = 3'd6,
    REG_YEAR = 3'd7
  } reg_sel_e;

  // binary calendar state
  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] date;
    logic [2:0] dow;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
  endfunction

  // bits a host may store in each visible register
  function automatic logic [7:0] wr_mask(input reg_sel_e s);
    logic [7:0] m;
    unique case (s)
      REG_CTRL: m = 8'hC0;
      REG_SEC:  m = 8'h7F;
      REG_MIN:  m = 8'h7F;
      REG_HOUR: m = 8'h3F;
      REG_DOW:  m = 8'h07;
      REG_DATE: m = 8'h3F;
      REG_MON:  m = 8'h1F;
      default:  m = 8'hFF;
    endcase
    return m;
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic leap);
    logic [4:0] d;
    unique case (m)
      4'd2:                    d = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
      default:                 d = 5'd31;
    endcase
    return d;
  endfunction

  localparam cal_t CAL_RESET = '{year: 7'd0, mon: 4'd1, date: 5'd1, dow: 3'd1,
                                 hour: 5'd0, min: 6'd0, sec: 6'd0};
endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic halt,
  input  logic load,
  input  cal_t load_val,
  output cal_t now
);
  cal_t       nxt;
  logic       leap;
  logic [4:0] dim;

  always_comb begin
    nxt  = now;
    leap = (now.year[1:0] == 2'b00);
    dim  = days_in_month(now.mon, leap);
    if (now.sec >= 6'd59) begin
      nxt.sec = 6'd0;
      if (now.min >= 6'd59) begin
        nxt.min = 6'd0;
        if (now.hour >= 5'd23) begin
          nxt.hour = 5'd0;
          nxt.dow  = (now.dow >= 3'd7) ? 3'd1 : now.dow + 3'd1;
          if (now.date >= dim) begin
            nxt.date = 5'd1;
            if (now.mon >= 4'd12) begin
              nxt.mon  = 4'd1;
              nxt.year = (now.year >= 7'd99) ? 7'd0 : now.year + 7'd1;
            end else begin
              nxt.mon = now.mon + 4'd1;
            end
          end else begin
            nxt.date = now.date + 5'd1;
          end
        end else begin
          nxt.hour = now.hour + 5'd1;
        end
      end else begin
        nxt.min = now.min + 6'd1;
      end
    end else begin
      nxt.sec = now.sec + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now <= CAL_RESET;
    end else if (load) begin
      now <= load_val;
    end else if (tick && !halt) begin
      now <= nxt;
    end
  end
endmodule

// File: rtl/rtc_access.sv
module rtc_access
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pwr_fail,
  output logic              win_wr,
  output logic              win_rd_oe,
  output reg_sel_e          sel,
  output logic              ram_ce_n,
  output logic              dq_oe,
  output logic              pf_n
);
  logic in_win;
  logic active;

  assign in_win    = &addr[ADDR_W-1:SEL_W];
  assign active    = !cs_n && !pwr_fail;
  assign sel       = reg_sel_e'(addr[SEL_W-1:0]);
  assign win_wr    = active && in_win && !we_n;
  assign win_rd_oe = active && in_win && we_n && !oe_n;
  assign ram_ce_n  = !(active && !in_win);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe <= 1'b0;
      pf_n  <= 1'b1;
    end else begin
      dq_oe <= win_rd_oe;
      pf_n  <= !pwr_fail;
    end
  end
endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  input  cal_t              live,
  output logic              load,
  output cal_t              load_val,
  output logic              osc_stop,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] vis      [NUM_REGS];
  logic [DATA_W-1:0] live_bcd [NUM_REGS];
  logic [DATA_W-1:0] rb;
  logic              ft;
  logic              tick_q;
  logic              hold_w;
  logic              hold_r;
  logic [6:0]        b_year, b_mon, b_date, b_dow, b_hour, b_min, b_sec;

  assign hold_w = vis[REG_CTRL][7];
  assign hold_r = vis[REG_CTRL][6];

  always_comb begin
    live_bcd[REG_CTRL] = '0;
    live_bcd[REG_SEC]  = bin2bcd({1'b0, live.sec});
    live_bcd[REG_MIN]  = bin2bcd({1'b0, live.min});
    live_bcd[REG_HOUR] = bin2bcd({2'b0, live.hour});
    live_bcd[REG_DOW]  = bin2bcd({4'b0, live.dow});
    live_bcd[REG_DATE] = bin2bcd({2'b0, live.date});
    live_bcd[REG_MON]  = bin2bcd({3'b0, live.mon});
    live_bcd[REG_YEAR] = bin2bcd(live.year);
  end

  always_comb begin
    b_sec  = bcd2bin(vis[REG_SEC]);
    b_min  = bcd2bin(vis[REG_MIN]);
    b_hour = bcd2bin(vis[REG_HOUR]);
    b_dow  = bcd2bin(vis[REG_DOW]);
    b_date = bcd2bin(vis[REG_DATE]);
    b_mon  = bcd2bin(vis[REG_MON]);
    b_year = bcd2bin(vis[REG_YEAR]);
    load_val.sec  = b_sec[5:0];
    load_val.min  = b_min[5:0];
    load_val.hour = b_hour[4:0];
    load_val.dow  = b_dow[2:0];
    load_val.date = b_date[4:0];
    load_val.mon  = b_mon[3:0];
    load_val.year = b_year;
  end

  // write-hold released by a control write with bit 7 clear
  assign load = wr_en && (sel == REG_CTRL) && hold_w && !wdata[7];

  always_comb begin
    unique case (sel)
      REG_SEC: rb = {osc_stop, vis[REG_SEC][6:0]};
      REG_DOW: rb = {1'b0, ft, 3'b000, vis[REG_DOW][2:0]};
      default: rb = vis[sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        vis[i] <= '0;
      end
      vis[REG_DOW]  <= 8'h01;
      vis[REG_DATE] <= 8'h01;
      vis[REG_MON]  <= 8'h01;
      ft       <= 1'b0;
      osc_stop <= 1'b0;
      tick_q   <= 1'b0;
      rdata    <= '0;
    end else begin
      tick_q <= tick;
      rdata  <= rd_en ? rb : '0;
      if (tick_q && !hold_w && !hold_r) begin
        for (int i = 1; i < NUM_REGS; i++) begin
          vis[i] <= live_bcd[i];
        end
      end
      if (wr_en) begin
        vis[sel] <= wdata & wr_mask(sel);
        if (sel == REG_SEC) osc_stop <= wdata[7];
        if (sel == REG_DOW) ft       <= wdata[6];
      end
    end
  end
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic              pwr_fail,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        dq_out,
  output logic              dq_oe,
  output logic              pf_n,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata
);
  logic     win_wr;
  logic     win_rd_oe;
  reg_sel_e sel;
  logic     load;
  logic     osc_stop;
  cal_t     load_val;
  cal_t     live;

  assign ram_oe_n  = oe_n;
  assign ram_we_n  = we_n;
  assign ram_addr  = addr;
  assign ram_wdata = wdata;

  rtc_access #(.ADDR_W(ADDR_W)) u_access (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .pwr_fail(pwr_fail), .win_wr(win_wr), .win_rd_oe(win_rd_oe),
    .sel(sel), .ram_ce_n(ram_ce_n), .dq_oe(dq_oe), .pf_n(pf_n)
  );

  rtc_window u_window (
    .clk(clk), .rst(rst), .tick(tick_1s), .wr_en(win_wr), .rd_en(win_rd_oe),
    .sel(sel), .wdata(wdata), .live(live), .load(load), .load_val(load_val),
    .osc_stop(osc_stop), .rdata(dq_out)
  );

  rtc_calendar u_calendar (
    .clk(clk), .rst(rst), .tick(tick_1s), .halt(osc_stop), .load(load),
    .load_val(load_val), .now(live)
  );
endmodule

// File: rtl/rtc_regwin_chk.sv
module rtc_regwin_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              pwr_fail,
  input logic              cs_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dq_out,
  input logic              dq_oe,
  input logic              pf_n,
  input logic              ram_ce_n
);
  logic in_win;
  assign in_win = &addr[ADDR_W-1:3];

  AST_PF_FLAG_LOW: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !pf_n); // R11
  AST_PF_FLAG_HIGH: assert property (@(posedge clk) disable iff (rst)
    !pwr_fail |=> pf_n); // R11
  AST_PF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !dq_oe); // R11
  AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> $past(!cs_n && we_n && !oe_n && in_win)); // R10
  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(addr[2:0] == 3'd0)) |-> (dq_out[5:0] == 6'd0)); // R2
  AST_MONTH_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (dq_oe && $past(addr[2:0] == 3'd6)) |-> (dq_out[7:5] == 3'd0)); // R9
  AST_RAM_CE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !ram_ce_n |-> (!cs_n && !pwr_fail && !in_win)); // R12
endmodule

bind rtc_regwin rtc_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .pwr_fail(pwr_fail), .cs_n(cs_n), .oe_n(oe_n),
  .we_n(we_n), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe), .pf_n(pf_n),
  .ram_ce_n(ram_ce_n)
);

// File: tb/rtc_regwin_tb.sv
`timescale 1ns/1ps
module rtc_regwin_tb;
  localparam int AW = 19;
  localparam logic [AW-1:0] WIN = 19'h7FFF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1s = 1'b0, pwr_fail = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] dq_out;
  logic dq_oe, pf_n, ram_ce_n, ram_oe_n, ram_we_n;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;

  always #2.5 clk = ~clk;

  rtc_regwin #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .pwr_fail(pwr_fail), .cs_n(cs_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata), .dq_out(dq_out),
    .dq_oe(dq_oe), .pf_n(pf_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string tag = "R1";

  // model: V = visible bytes, L = live binary (index as register select)
  int V[8];
  int L[8];
  bit m_stop, m_ft, m_tq;
  int MASK[8] = '{8'hC0, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int to_bcd(int v); return (v / 10) * 16 + v % 10; endfunction
  function automatic int from_bcd(int b); return (b / 16) * 10 + b % 16; endfunction
  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic m_advance();
    L[1]++;
    if (L[1] == 60) begin
      L[1] = 0; L[2]++;
      if (L[2] == 60) begin
        L[2] = 0; L[3]++;
        if (L[3] == 24) begin
          L[3] = 0;
          L[4] = L[4] % 7 + 1;
          L[5]++;
          if (L[5] > mdays(L[6], L[7])) begin
            L[5] = 1; L[6]++;
            if (L[6] > 12) begin L[6] = 1; L[7] = (L[7] + 1) % 100; end
          end
        end
      end
    end
  endtask

  function automatic int m_read(int s);
    if (s == 1) return (m_stop ? 128 : 0) + V[1];
    if (s == 4) return (m_ft ? 64 : 0) + V[4];
    return V[s];
  endfunction

  task automatic m_reset();
    V = '{0, 0, 0, 0, 1, 1, 1, 0};
    L = '{0, 0, 0, 0, 1, 1, 1, 0};
    m_stop = 0; m_ft = 0; m_tq = 0;
  endtask

  // one bus cycle: drive, step model, clock, compare
  task automatic cyc(bit c, bit o, bit w, logic [AW-1:0] a, logic [7:0] d, bit t, bit p);
    bit inwin, act, wr, rd, e_oe, ld;
    int s, e_dq, e_ce;
    int oldL[8];
    int oldV[8];
    cs_n = c; oe_n = o; we_n = w; addr = a; wdata = d; tick_1s = t; pwr_fail = p;
    inwin = (a[AW-1:3] == '1);
    s = int'(a[2:0]);
    act = !c && !p;
    wr = act && inwin && !w;
    rd = act && inwin && w;
    e_oe = rd && !o;
    e_dq = m_read(s);
    e_ce = (act && !inwin) ? 0 : 1;
    oldL = L; oldV = V;
    ld = wr && s == 0 && oldV[0][7] && !d[7];
    if (ld) begin
      for (int i = 1; i < 8; i++) L[i] = from_bcd(oldV[i]);
    end else if (t && !m_stop) begin
      m_advance();
    end
    if (m_tq && (oldV[0] & 8'hC0) == 0) begin
      for (int i = 1; i < 8; i++) V[i] = to_bcd(oldL[i]);
    end
    if (wr) begin
      V[s] = d & MASK[s];
      if (s == 1) m_stop = d[7];
      if (s == 4) m_ft = d[6];
    end
    m_tq = t;
    @(posedge clk);
    @(negedge clk);
    chk(tag, dq_oe, e_oe, "dq_oe");
    if (e_oe) chk(tag, dq_out, e_dq, "dq_out");
    chk(tag, pf_n, !p, "pf_n");
    chk(tag, ram_ce_n, e_ce, "ram_ce_n");
  endtask

  task automatic idle(); cyc(1, 1, 1, '0, 8'h00, 0, 0); endtask
  task automatic do_tick(); cyc(1, 1, 1, '0, 8'h00, 1, 0); idle(); endtask
  task automatic wr_reg(int s, logic [7:0] d); cyc(0, 1, 0, WIN | AW'(s), d, 0, 0); endtask
  task automatic rd_reg(int s, int exp, string req);
    cyc(0, 0, 1, WIN | AW'(s), 8'h00, 0, 0);
    chk(req, dq_out, exp, $sformatf("reg%0d", s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10", dq_oe, 0, "dq_oe after reset");
    chk("R11", pf_n, 1, "pf_n after reset");

    tag = "R1"; // reset map
    rd_reg(7, 8'h00, "R1"); rd_reg(6, 8'h01, "R1"); rd_reg(5, 8'h01, "R1");
    rd_reg(4, 8'h01, "R1"); rd_reg(3, 8'h00, "R1"); rd_reg(2, 8'h00, "R1");
    rd_reg(1, 8'h00, "R1"); rd_reg(0, 8'h00, "R1");

    tag = "R3";
    repeat (3) do_tick();
    rd_reg(1, 8'h03, "R3");

    tag = "R4";
    wr_reg(0, 8'h40);
    rd_reg(0, 8'h40, "R2");
    repeat (5) do_tick();
    rd_reg(1, 8'h03, "R4");
    wr_reg(0, 8'h00);
    rd_reg(1, 8'h03, "R4");
    do_tick();
    rd_reg(1, 8'h09, "R4");

    tag = "R5";
    wr_reg(0, 8'h80);
    wr_reg(7, 8'h99); wr_reg(6, 8'h12); wr_reg(5, 8'h31); wr_reg(4, 8'h07);
    wr_reg(3, 8'h23); wr_reg(2, 8'h59); wr_reg(1, 8'h59);
    do_tick();
    rd_reg(1, 8'h59, "R5");
    rd_reg(0, 8'h80, "R2");
    wr_reg(0, 8'h00);
    tag = "R6";
    do_tick();
    rd_reg(1, 8'h00, "R6"); rd_reg(2, 8'h00, "R6"); rd_reg(3, 8'h00, "R6");
    rd_reg(4, 8'h01, "R6"); rd_reg(5, 8'h01, "R6"); rd_reg(6, 8'h01, "R6");
    rd_reg(7, 8'h00, "R5");

    wr_reg(0, 8'h80);
    wr_reg(7, 8'h24); wr_reg(6, 8'h02); wr_reg(5, 8'h28);
    wr_reg(3, 8'h23); wr_reg(2, 8'h59); wr_reg(1, 8'h59);
    wr_reg(0, 8'h00);
    do_tick();
    rd_reg(5, 8'h29, "R6"); rd_reg(6, 8'h02, "R6");
    wr_reg(0, 8'h80);
    wr_reg(7, 8'h23); wr_reg(5, 8'h28);
    wr_reg(3, 8'h23); wr_reg(2, 8'h59); wr_reg(1, 8'h59);
    wr_reg(0, 8'h00);
    do_tick();
    rd_reg(5, 8'h01, "R6"); rd_reg(6, 8'h03, "R6");

    tag = "R7";
    wr_reg(0, 8'h80);
    wr_reg(1, 8'h80);
    wr_reg(0, 8'h00);
    repeat (3) do_tick();
    rd_reg(1, 8'h80, "R7");
    wr_reg(1, 8'h00);
    do_tick();
    rd_reg(1, 8'h01, "R7");

    tag = "R8";
    wr_reg(4, 8'h47);
    rd_reg(4, 8'h47, "R8");
    wr_reg(4, 8'hFF);
    rd_reg(4, 8'h47, "R9");
    wr_reg(4, 8'h00);
    rd_reg(4, 8'h00, "R8");
    do_tick();

    tag = "R9";
    wr_reg(6, 8'hFF);
    rd_reg(6, 8'h1F, "R9");
    wr_reg(0, 8'h3F);
    rd_reg(0, 8'h00, "R9");
    wr_reg(3, 8'hFF);
    rd_reg(3, 8'h3F, "R9");
    wr_reg(2, 8'hFF);
    rd_reg(2, 8'h7F, "R9");
    do_tick();

    tag = "R10";
    cyc(0, 1, 1, WIN, 8'h00, 0, 0);
    chk("R10", dq_oe, 0, "no drive with oe_n high");
    cyc(1, 0, 1, WIN, 8'h00, 0, 0);
    chk("R10", dq_oe, 0, "no drive with cs_n high");
    cyc(0, 0, 0, WIN, 8'h00, 0, 0);
    chk("R10", dq_oe, 0, "no drive on write");

    tag = "R11";
    cyc(0, 1, 0, WIN, 8'h80, 1, 1);
    chk("R11", pf_n, 0, "pf_n during fail");
    cyc(0, 0, 1, WIN, 8'h00, 0, 1);
    chk("R11", dq_oe, 0, "no drive during fail");
    idle();
    chk("R11", pf_n, 1, "pf_n after recovery");
    rd_reg(0, 8'h00, "R11");
    idle();

    tag = "R12";
    cyc(0, 0, 1, 19'h00123, 8'h5A, 0, 0);
    chk("R12", ram_ce_n, 0, "ram ce outside window");
    chk("R12", int'(ram_addr), 19'h00123, "ram_addr");
    chk("R12", ram_wdata, 8'h5A, "ram_wdata");
    chk("R12", ram_oe_n, 0, "ram_oe_n");
    cyc(0, 0, 1, WIN | 19'd3, 8'h00, 0, 0);
    chk("R12", ram_ce_n, 1, "ram ce inside window");
    cyc(0, 1, 0, 19'h00040, 8'h00, 0, 1);
    chk("R12", ram_ce_n, 1, "ram ce during fail");
    chk("R12", ram_we_n, 0, "ram_we_n");
    idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule